// File: doc/BRIEF.md
# Synchronous serial receiver with FIFO

This block takes in a serial bit stream on its clock, one bit per rising edge. It builds each bit into an 8-bit word in a shift register and writes every finished word into a 16-entry receive FIFO. The reading side sees the oldest word on a read port, pops it with a one-cycle read strobe and can watch the FIFO level. A ready flag is high while the FIFO holds at least a programmable number of words.

Two framing modes are supported. In start-signal mode, a frame-sync pulse marks the first bit of every word. Bits that arrive between the end of a word and the next sync are dropped. In continuous mode, one sync starts the stream and words then follow one another with no gap and no further sync. The bit order can be LSB first or MSB first. A write into a full FIFO discards the word and sets a sticky overrun flag. A synchronous reset empties the FIFO and throws away any word that is partly received.

Top module: `srx_fifo_top`

## Requirements
- R1: When rst is high at a rising edge, the FIFO is emptied (level 0), overrun is cleared and any partly received word is discarded, so bits received after reset without a new sync produce no word.
- R2: In start-signal mode (cfg_continuous = 0), the bit present on sdata at the edge where fsync is high is the first bit of a word. The following 7 edges supply the remaining bits.
- R3: In start-signal mode, bits present after a word completes and before the next fsync are ignored, and the FIFO level does not change because of them.
- R4: In continuous mode (cfg_continuous = 1), a single fsync starts reception. After that, the first bit of each word is taken on the edge right after the last bit of the previous word, with no further sync.
- R5: With cfg_msb_first = 0, the first bit received becomes bit 0 of the word and the eighth becomes bit 7.
- R6: With cfg_msb_first = 1, the first bit received becomes bit 7 of the word and the eighth becomes bit 0.
- R7: A completed word is written to the FIFO at the same edge that captures its last bit, so level rises by one at that edge.
- R8: The FIFO delivers words in arrival order. rd_data shows the oldest word, and rd_en high at an edge removes it and lowers level by one. rd_en while the FIFO is empty has no effect.
- R9: ready is high exactly when level >= cfg_watermark. It falls as soon as reads bring level below the watermark.
- R10: The FIFO holds 16 words. A word that completes while the FIFO is full and no read happens at that edge is discarded and sets overrun. overrun stays set until reset.
- R11: In start-signal mode, an fsync during a partly received word discards that partial word, and capture restarts with the current bit as bit one of a new word.
- R12: In continuous mode, fsync while reception is running is ignored and does not disturb word alignment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_continuous | input | 1 | 0 = sync before every word, 1 = back-to-back words after one sync |
| cfg_msb_first | input | 1 | 0 = first bit to bit 0, 1 = first bit to bit 7 |
| cfg_watermark | input | 4 | Level at or above which ready is high |
| fsync | input | 1 | Frame sync marking a word's first bit |
| sdata | input | 1 | Serial data bit |
| rd_en | input | 1 | Pop the oldest word at this edge |
| rd_data | output | 8 | Oldest word in the FIFO |
| level | output | 5 | Number of words held (0 to 16) |
| ready | output | 1 | High while level >= cfg_watermark |
| overrun | output | 1 | Sticky flag for a word lost to a full FIFO |

## Verification
Every 8-bit value is sent in start-signal mode in both bit orders, with toggling junk bits in the gap before each next sync. This tells a correct bit-to-position mapping apart from a reversed or shifted one, and shows whether inter-word bits leak into the FIFO. In continuous mode, a stream of all 256 values (LSB first) and a scrambled stream (MSB first) run with stray syncs inside words. These show whether word boundaries stay locked to the first sync. A full fill sweeps every watermark value at every level and checks that words come out in order. An overfill, a mid-word sync and a reset during a partial word separate discard and restart behaviour from silent corruption.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic {
        FRAME_PER_WORD = 1'b0,
        FRAME_STREAM   = 1'b1
    } frame_mode_e;

    typedef enum logic {
        ORDER_LSB = 1'b0,
        ORDER_MSB = 1'b1
    } bit_order_e;

    localparam int unsigned SRX_WORD_W = 8;
    localparam int unsigned SRX_DEPTH  = 16;
    localparam int unsigned SRX_WM_W   = 4;

endpackage

// File: rtl/srx_deser.sv
module srx_deser
    import srx_pkg::*;
#(
    parameter int unsigned WORD_W = SRX_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  frame_mode_e       mode,
    input  bit_order_e        order,
    input  logic              fsync,
    input  logic              sdata,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_data,
    output logic              active
);
    localparam int unsigned CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] shifted;
    logic              start_now;
    logic              take;
    logic [CNT_W-1:0]  bit_idx;
    logic              last;

    // A sync opens a word in per-word framing at any time; in stream
    // framing only while no word is running.
    assign start_now = fsync && (mode == FRAME_PER_WORD || !active);
    assign take      = start_now || active;
    assign bit_idx   = start_now ? '0 : cnt;
    assign last      = take && (bit_idx == LAST_IDX);

    always_comb begin
        if (order == ORDER_LSB) shifted = {sdata, shreg[WORD_W-1:1]};
        else                    shifted = {shreg[WORD_W-2:0], sdata};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (take) begin
            shreg <= shifted;
            if (last) begin
                cnt    <= '0;
                active <= (mode == FRAME_STREAM);
            end else begin
                cnt    <= bit_idx + 1'b1;
                active <= 1'b1;
            end
        end
    end

    assign word_vld  = last && !rst;
    assign word_data = shifted;

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [WIDTH-1:0]           push_data,
    input  logic                       pop,
    output logic [WIDTH-1:0]           head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       lost
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned LW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             full;
    logic             pop_ok;
    logic             push_ok;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == LW'(DEPTH));
    assign pop_ok  = pop && (count != '0);
    assign push_ok = push && (!full || pop_ok);

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            lost   <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && !push_ok) lost <= 1'b1;
        end
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/srx_fifo_top.sv
module srx_fifo_top
    import srx_pkg::*;
#(
    parameter int unsigned WORD_W = SRX_WORD_W,
    parameter int unsigned DEPTH  = SRX_DEPTH,
    parameter int unsigned WM_W   = SRX_WM_W,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_continuous,
    input  logic              cfg_msb_first,
    input  logic [WM_W-1:0]   cfg_watermark,
    input  logic              fsync,
    input  logic              sdata,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic [LVL_W-1:0]  level,
    output logic              ready,
    output logic              overrun
);
    frame_mode_e       mode;
    bit_order_e        order;
    logic              word_vld;
    logic [WORD_W-1:0] word_data;
    logic              eng_active;

    assign mode  = frame_mode_e'(cfg_continuous);
    assign order = bit_order_e'(cfg_msb_first);

    srx_deser #(.WORD_W(WORD_W)) u_deser (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .order     (order),
        .fsync     (fsync),
        .sdata     (sdata),
        .word_vld  (word_vld),
        .word_data (word_data),
        .active    (eng_active)
    );

    srx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (word_vld),
        .push_data (word_data),
        .pop       (rd_en),
        .head      (rd_data),
        .count     (level),
        .lost      (overrun)
    );

    assign ready = (level >= LVL_W'(cfg_watermark));

endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LVL_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_cont,
    input logic             fsync,
    input logic             rd_en,
    input logic             eng_active,
    input logic             word_vld,
    input logic [LVL_W-1:0] level,
    input logic             overrun
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (level == '0 && !overrun)); // R1

    AST_GAP_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!mode_cont && !eng_active && !fsync && !rd_en) |=> $stable(level)); // R3

    AST_STREAM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (mode_cont && eng_active) |=> eng_active); // R4

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
        (word_vld && !rd_en && level < FULL_LVL) |=> level == $past(level) + 1'b1); // R7

    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (level == '0 && rd_en && !word_vld) |=> level == '0); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LVL); // R10

    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
        (level == FULL_LVL && word_vld && !rd_en) |=> overrun); // R10

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R10

endmodule

bind srx_fifo_top srx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_cont  (cfg_continuous),
    .fsync      (fsync),
    .rd_en      (rd_en),
    .eng_active (eng_active),
    .word_vld   (word_vld),
    .level      (level),
    .overrun    (overrun)
);

// File: tb/srx_fifo_top_test.sv
module srx_fifo_top_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_continuous = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic [3:0] cfg_watermark = 4'd1;
    logic       fsync = 1'b0;
    logic       sdata = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] level;
    logic       ready;
    logic       overrun;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    srx_fifo_top uut (
        .clk            (clk),
        .rst            (rst),
        .cfg_continuous (cfg_continuous),
        .cfg_msb_first  (cfg_msb_first),
        .cfg_watermark  (cfg_watermark),
        .fsync          (fsync),
        .sdata          (sdata),
        .rd_en          (rd_en),
        .rd_data        (rd_data),
        .level          (level),
        .ready          (ready),
        .overrun        (overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic d, input logic r);
        @(negedge clk);
        fsync = s;
        sdata = d;
        rd_en = r;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; fsync = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic bit_at(input logic [7:0] w, input bit msb, input int i);
        return msb ? w[7-i] : w[i];
    endfunction

    task automatic send_word(input logic [7:0] w, input bit msb);
        for (int i = 0; i < 8; i++) step(i == 0, bit_at(w, msb, i), 1'b0);
    endtask

    // Per-word framing: word, three junk gap bits, pop.
    task automatic framed_sweep(input bit msb);
        do_reset();
        cfg_continuous = 1'b0;
        cfg_msb_first  = msb;
        for (int k = 0; k < 256; k++) begin
            logic [7:0] w;
            w = 8'(k);
            send_word(w, msb);
            step(1'b0, ~w[0], 1'b0);
            chk(level == 5'd1, "R7 level after last bit", level, 1);
            chk(rd_data == w, msb ? "R6 msb word" : "R5/R2 lsb word", rd_data, w);
            step(1'b0, w[1], 1'b0);
            step(1'b0, 1'b1, 1'b0);
            step(1'b0, 1'b0, 1'b1);
            chk(level == 5'd1, "R3 gap bits ignored", level, 1);
            step(1'b0, 1'b1, 1'b0);
            chk(level == 5'd0, "R8 pop", level, 0);
        end
    endtask

    function automatic logic [7:0] stream_val(input bit msb, input int k);
        return msb ? 8'((k * 37 + 11) & 255) : 8'(k);
    endfunction

    // Continuous framing with stray syncs (R12) and reads during reception.
    task automatic stream_run(input bit msb, input int n);
        do_reset();
        cfg_continuous = 1'b1;
        cfg_msb_first  = msb;
        for (int k = 0; k <= n; k++) begin
            logic [7:0] w;
            w = (k < n) ? stream_val(msb, k) : 8'h00;
            for (int i = 0; i < 8; i++) begin
                logic s;
                logic r;
                s = (k == 0 && i == 0) || (k % 5 == 3 && i == 4);
                r = (k > 0 && i == 2);
                step(s, bit_at(w, msb, i), r);
                if (r) begin
                    chk(rd_data == stream_val(msb, k - 1), "R4/R12 stream word",
                        rd_data, stream_val(msb, k - 1));
                    chk(level == 5'd1, "R4 stream level", level, 1);
                end
            end
        end
        do_reset();
        cfg_continuous = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        step(1'b0, 1'b0, 1'b0);
        chk(level == 5'd0, "R1 reset level", level, 0);
        chk(overrun == 1'b0, "R1 reset overrun", overrun, 0);
        chk(ready == 1'b0, "R9 ready at reset wm=1", ready, 0);

        framed_sweep(1'b0);
        framed_sweep(1'b1);
        stream_run(1'b0, 256);
        stream_run(1'b1, 64);

        // R11: mid-word sync restarts capture
        do_reset();
        cfg_msb_first = 1'b0;
        for (int i = 0; i < 5; i++) step(i == 0, 1'b1, 1'b0);
        send_word(8'h5A, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk(level == 5'd1, "R11 one word after restart", level, 1);
        chk(rd_data == 8'h5A, "R11 restarted word", rd_data, 8'h5A);

        // R1: reset aborts a partial word
        do_reset();
        for (int i = 0; i < 4; i++) step(i == 0, 1'b1, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0);
        chk(level == 5'd0, "R1 partial word aborted", level, 0);

        // R8/R9: fill, order and every watermark at every level
        do_reset();
        for (int i = 0; i < 16; i++) send_word(8'(i * 17), 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk(level == 5'd16, "R10 holds 16", level, 16);
        chk(overrun == 1'b0, "R10 no overrun at 16", overrun, 0);
        for (int l = 16; l >= 1; l--) begin
            for (int m = 0; m < 16; m++) begin
                cfg_watermark = 4'(m);
                #1;
                chk(ready == (l >= m), "R9 ready vs watermark", ready, int'(l >= m));
            end
            chk(rd_data == 8'((16 - l) * 17), "R8 order", rd_data, (16 - l) * 17);
            step(1'b0, 1'b0, 1'b1);
            step(1'b0, 1'b0, 1'b0);
            chk(level == 5'(l - 1), "R8 level after pop", level, l - 1);
        end
        cfg_watermark = 4'd0; #1;
        chk(ready == 1'b1, "R9 wm=0 empty", ready, 1);
        cfg_watermark = 4'd1; #1;
        chk(ready == 1'b0, "R9 ready falls", ready, 0);

        // R10: overfill
        do_reset();
        for (int i = 0; i < 17; i++) send_word((i < 16) ? 8'(8'h30 + i) : 8'hEE, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk(level == 5'd16, "R10 level capped", level, 16);
        chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
        for (int i = 0; i < 16; i++) begin
            chk(rd_data == 8'(8'h30 + i), "R10 kept words", rd_data, 8'h30 + i);
            step(1'b0, 1'b0, 1'b1);
            step(1'b0, 1'b0, 1'b0);
        end
        chk(level == 5'd0, "R10 drained", level, 0);
        chk(overrun == 1'b1, "R10 overrun sticky", overrun, 1);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        chk(level == 5'd0, "R8 pop on empty", level, 0);
        do_reset();
        step(1'b0, 1'b0, 1'b0);
        chk(overrun == 1'b0, "R1 reset clears overrun", overrun, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule